// File: doc/BRIEF.md
# Packed-Time Real-Time Clock

This block keeps wall-clock time as one 32-bit packed word: seconds, minutes and hours sit in fixed bit fields at the bottom, and a free-running day count fills the top fifteen bits. A one-hertz tick from an external divider advances the word. Counting only happens while bit 0 of the prescaler-enable register is set. Software sets the time by writing the packed word. The new time is held in a shadow and takes effect on the next counting tick, and a protected pending flag in the interrupt status register shows that a load is waiting.

Around the counter sit a stopwatch down-counter, an alarm comparator and an interrupt status register with write-one-to-clear bits. These combine with an interrupt-control mask to drive a single interrupt line. The register bank sits behind a simple synchronous bus with a byte address and a byte-count access size. The bus registers its response one cycle after each request. It reports an illegal access size ahead of an access to an unmapped or misaligned offset.

Top module: `rtc_packed_top`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and the bus response outputs (`bus_rdata`, `bus_err_code`) are 0.
- R2: The time word holds seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. Each counting tick with no load pending adds one second.
- R3: On a tick, the seconds field goes to 0 from 59 or above and carries into minutes. Minutes do the same at 59 or above and carry into hours. Hours go to 0 from 23 or above and carry into days. The day field wraps from 0x7FFF to 0.
- R4: Register slots sit 4 bytes apart from offset 0x00: time 0x00 (32-bit), interrupt mask 0x04, interrupt status 0x08, stopwatch 0x0C, alarm 0x10 (32-bit) and prescaler enable 0x14. The 16-bit registers read back zero-extended. A 2-byte access to a 32-bit register reads or writes only its low 16 bits.
- R5: A write to the time register leaves the readable time unchanged and sets status bit 14. The next counting tick loads the written value instead of incrementing and clears bit 14. A 2-byte write takes the upper half from the time current at the write.
- R6: Writing the interrupt status register clears each of bits 0, 1 and 2 written as 1. Bit 14 is never changed by such a write. A flag set by a tick in the same cycle wins over the clear.
- R7: `bus_err_code` is 1 for an access size other than 2 or 4 bytes, even at an unmapped offset. It is 2 for a legal size at a misaligned offset or an offset of 0x18 or above, and 0 otherwise. An errored access changes no register and returns zero data.
- R8: When the time produced by a counting tick equals the alarm register, status bit 1 is set.
- R9: Every counting tick sets status bit 0. A counting tick decrements a nonzero stopwatch by one, and sets status bit 2 when the count reaches zero.
- R10: `irq` is high exactly when some status bit and the same interrupt-mask bit are both 1.
- R11: When prescaler-enable bit 0 is 0, a tick changes nothing: the time, the stopwatch and the status bits stay as they were.
- R12: Read data and the error code appear in the cycle after the request. They are 0 in any cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset into the register bank |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err_code | output | 2 | Registered error code: 0 ok, 1 bad size, 2 unmapped |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that at most one bus request arrives per cycle. They also assume that a time write and the counting tick meant to apply it fall in different cycles. The bench drives inputs only on falling edges and issues one request or one tick per operation, so it never overlaps a time load with a tick. The random phase draws register offsets, data, sizes and illegal accesses from a fixed seed, while directed cases cover the rollovers and the error priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DAY_W  = 15;
    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;
    localparam int WORD_W = DAY_W + HOUR_W + MIN_W + SEC_W;
    localparam int HALF_W = WORD_W / 2;

    localparam int FLAG_SEC  = 0;
    localparam int FLAG_ALM  = 1;
    localparam int FLAG_SW   = 2;
    localparam int FLAG_PEND = 14;
    localparam int NUM_FLAGS = 3;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        SLOT_TIME  = 3'd0,
        SLOT_MASK  = 3'd1,
        SLOT_FLAGS = 3'd2,
        SLOT_SW    = 3'd3,
        SLOT_ALARM = 3'd4,
        SLOT_PREN  = 3'd5,
        SLOT_NONE  = 3'd7
    } rtc_slot_e;

    typedef enum logic [1:0] {
        ACC_OK   = 2'd0,
        ACC_SIZE = 2'd1,
        ACC_MAP  = 2'd2
    } rtc_acc_e;

    function automatic rtc_time_t time_advance(input rtc_time_t t);
        rtc_time_t n;
        logic      c_min, c_hour, c_day;
        n      = t;
        c_min  = (t.sec  >= SEC_W'(SEC_LAST));
        c_hour = c_min  && (t.min  >= MIN_W'(MIN_LAST));
        c_day  = c_hour && (t.hour >= HOUR_W'(HOUR_LAST));
        n.sec  = c_min  ? '0 : t.sec + 1'b1;
        if (c_min)  n.min  = c_hour ? '0 : t.min + 1'b1;
        if (c_hour) n.hour = c_day  ? '0 : t.hour + 1'b1;
        if (c_day)  n.day  = t.day + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 3,
    parameter int SLOTS  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output rtc_slot_e         slot,
    output rtc_acc_e          acc,
    output logic              half
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] SLOT_LIM = IDX_W'(SLOTS);

    logic [IDX_W-1:0] idx;
    logic             size_ok;

    assign idx     = addr[ADDR_W-1:2];
    assign size_ok = (size == SIZE_W'(2)) || (size == SIZE_W'(4));
    assign half    = (size == SIZE_W'(2));

    always_comb begin
        slot = SLOT_NONE;
        acc  = ACC_OK;
        if (!size_ok) begin
            acc = ACC_SIZE;
        end else if ((addr[1:0] != 2'b00) || (idx >= SLOT_LIM)) begin
            acc = ACC_MAP;
        end else begin
            slot = rtc_slot_e'(idx[2:0]);
        end
    end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               count_en,
    input  logic               load_we,
    input  logic               load_half,
    input  logic [WORD_W-1:0]  load_data,
    output rtc_time_t          time_q,
    output rtc_time_t          time_next,
    output logic               pend_q
);
    rtc_time_t shadow_q;

    assign time_next = pend_q ? shadow_q : time_advance(time_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q   <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (count_en) begin
                time_q <= time_next;
                pend_q <= 1'b0;
            end
            if (load_we) begin
                shadow_q <= load_half ? {time_q[WORD_W-1:HALF_W], load_data[HALF_W-1:0]}
                                      : load_data;
                pend_q   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
    import rtc_pkg::*;
#(
    parameter int SW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  rtc_time_t         time_next,
    input  logic [WORD_W-1:0] alarm,
    input  logic              pend,
    input  logic [HALF_W-1:0] mask,
    input  logic              sw_we,
    input  logic [SW_W-1:0]   sw_data,
    input  logic              clr_we,
    input  logic [HALF_W-1:0] clr_data,
    output logic [SW_W-1:0]   sw_q,
    output logic [HALF_W-1:0] flags_view,
    output logic              irq
);
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;

    always_comb begin
        set_v            = '0;
        set_v[FLAG_SEC]  = count_en;
        set_v[FLAG_ALM]  = count_en && (time_next == alarm);
        set_v[FLAG_SW]   = count_en && !sw_we && (sw_q == SW_W'(1));
        clr_v            = clr_we ? clr_data[NUM_FLAGS-1:0] : '0;
    end

    always_comb begin
        flags_view                  = '0;
        flags_view[NUM_FLAGS-1:0]   = flags_q;
        flags_view[FLAG_PEND]       = pend;
    end

    assign irq = |(flags_view & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            sw_q    <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_v) | set_v;
            if (sw_we) begin
                sw_q <= sw_data;
            end else if (count_en && (sw_q != '0)) begin
                sw_q <= sw_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_packed_top.sv
module rtc_packed_top
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 3,
    parameter int SW_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [1:0]        bus_err_code,
    output logic              irq
);
    rtc_slot_e         slot;
    rtc_acc_e          acc;
    logic              half;
    logic              acc_ok, wr_ok;
    logic              count_en;
    rtc_time_t         time_q, time_next;
    logic              pend_q;
    logic [HALF_W-1:0] mask_q, pren_q, flags_view;
    logic [WORD_W-1:0] alarm_q;
    logic [SW_W-1:0]   sw_q;
    logic              time_we, sw_we, flags_we;
    logic [WORD_W-1:0] rd_val;
    logic [WORD_W-1:0] rdata_q;
    rtc_acc_e          err_q;

    rtc_bus_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dec (
        .addr(bus_addr), .size(bus_size), .slot(slot), .acc(acc), .half(half)
    );

    assign acc_ok   = bus_valid && (acc == ACC_OK);
    assign wr_ok    = acc_ok && bus_write;
    assign time_we  = wr_ok && (slot == SLOT_TIME);
    assign sw_we    = wr_ok && (slot == SLOT_SW);
    assign flags_we = wr_ok && (slot == SLOT_FLAGS);
    assign count_en = tick && pren_q[0];

    rtc_timekeeper u_time (
        .clk(clk), .rst(rst), .count_en(count_en),
        .load_we(time_we), .load_half(half), .load_data(bus_wdata),
        .time_q(time_q), .time_next(time_next), .pend_q(pend_q)
    );

    rtc_event_unit #(.SW_W(SW_W)) u_evt (
        .clk(clk), .rst(rst), .count_en(count_en), .time_next(time_next),
        .alarm(alarm_q), .pend(pend_q), .mask(mask_q),
        .sw_we(sw_we), .sw_data(bus_wdata[SW_W-1:0]),
        .clr_we(flags_we), .clr_data(bus_wdata[HALF_W-1:0]),
        .sw_q(sw_q), .flags_view(flags_view), .irq(irq)
    );

    always_comb begin
        case (slot)
            SLOT_TIME:  rd_val = time_q;
            SLOT_MASK:  rd_val = WORD_W'(mask_q);
            SLOT_FLAGS: rd_val = WORD_W'(flags_view);
            SLOT_SW:    rd_val = WORD_W'(sw_q);
            SLOT_ALARM: rd_val = alarm_q;
            SLOT_PREN:  rd_val = WORD_W'(pren_q);
            default:    rd_val = '0;
        endcase
        if (half) rd_val = {{HALF_W{1'b0}}, rd_val[HALF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            pren_q  <= '0;
            alarm_q <= '0;
            rdata_q <= '0;
            err_q   <= ACC_OK;
        end else begin
            rdata_q <= '0;
            err_q   <= ACC_OK;
            if (bus_valid) err_q <= acc;
            if (acc_ok && !bus_write) rdata_q <= rd_val;
            if (wr_ok) begin
                case (slot)
                    SLOT_MASK:  mask_q  <= bus_wdata[HALF_W-1:0];
                    SLOT_PREN:  pren_q  <= bus_wdata[HALF_W-1:0];
                    SLOT_ALARM: alarm_q <= half ? {alarm_q[WORD_W-1:HALF_W], bus_wdata[HALF_W-1:0]}
                                                : bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_err_code = err_q;
endmodule

// File: rtl/rtc_packed_chk.sv
module rtc_packed_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [2:0]  bus_size,
    input logic [31:0] bus_rdata,
    input logic [1:0]  bus_err_code,
    input logic [31:0] time_w,
    input logic        pend_w,
    input logic [15:0] pren_w,
    input logic [15:0] flags_w,
    input logic [15:0] sw_w,
    input logic        sw_we_w,
    input logic        flags_we_w
);
    AST_SIZE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !(bus_size == 3'd2 || bus_size == 3'd4)) |=> (bus_err_code == 2'd1)); // R7
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_err_code != 2'd0) |-> (bus_rdata == 32'd0)); // R7
    AST_IDLE_RESP: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> (bus_err_code == 2'd0 && bus_rdata == 32'd0)); // R12
    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tick && pren_w[0] && !pend_w) |=> (time_w[5:0] < 6'd60)); // R3
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!(tick && pren_w[0]) && !(bus_valid && bus_write)) |=> $stable(time_w)); // R11
    AST_PROT_BIT: assert property (@(posedge clk) disable iff (rst)
        (flags_we_w && !(tick && pren_w[0])) |=> $stable(flags_w[14])); // R6
    AST_SW_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && pren_w[0] && sw_w != 16'd0 && !sw_we_w) |=> (sw_w == $past(sw_w) - 16'd1)); // R9
endmodule

bind rtc_packed_top rtc_packed_chk chk_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_err_code(bus_err_code),
    .time_w(time_q), .pend_w(pend_q), .pren_w(pren_q), .flags_w(flags_view),
    .sw_w(sw_q), .sw_we_w(sw_we), .flags_we_w(flags_we)
);

// File: tb/rtc_packed_top_tb_top.sv
`timescale 1ns/1ps
module rtc_packed_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  bus_err_code;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_time, m_shadow, m_alarm;
    logic [15:0] m_mask, m_pren, m_sw;
    logic [2:0]  m_flags;
    logic        m_pend;

    always #10 clk = ~clk;

    rtc_packed_top dut_i (
        .clk(clk), .rst(rst), .tick(tick), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err_code(bus_err_code), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] f_next(input logic [31:0] t);
        int s, mi, h, d;
        s = int'(t[5:0]); mi = int'(t[11:6]); h = int'(t[16:12]); d = int'(t[31:17]);
        if (s >= 59) begin
            s = 0;
            if (mi >= 59) begin
                mi = 0;
                if (h >= 23) begin h = 0; d = (d + 1) % 32768; end
                else h++;
            end else mi++;
        end else s++;
        return {d[14:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    function automatic logic [31:0] f_pack(input int d, input int h, input int mi, input int s);
        return {d[14:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    function automatic logic [1:0] f_err(input logic [7:0] a, input logic [2:0] sz);
        if (!(sz == 3'd2 || sz == 3'd4)) return 2'd1;
        if (a[1:0] != 2'b00 || a >= 8'h18) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [15:0] f_flags();
        logic [15:0] v;
        v = {13'd0, m_flags};
        v[14] = m_pend;
        return v;
    endfunction

    function automatic logic [31:0] f_read(input logic [7:0] a, input logic [2:0] sz);
        logic [31:0] v;
        case (a)
            8'h00: v = m_time;
            8'h04: v = {16'd0, m_mask};
            8'h08: v = {16'd0, f_flags()};
            8'h0C: v = {16'd0, m_sw};
            8'h10: v = m_alarm;
            8'h14: v = {16'd0, m_pren};
            default: v = '0;
        endcase
        if (sz == 3'd2) v = {16'd0, v[15:0]};
        return v;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        case (a)
            8'h00: begin m_shadow = (sz == 3'd2) ? {m_time[31:16], d[15:0]} : d; m_pend = 1'b1; end
            8'h04: m_mask = d[15:0];
            8'h08: m_flags = m_flags & ~d[2:0];
            8'h0C: m_sw = d[15:0];
            8'h10: m_alarm = (sz == 3'd2) ? {m_alarm[31:16], d[15:0]} : d;
            8'h14: m_pren = d[15:0];
            default: ;
        endcase
    endtask

    task automatic model_tick();
        logic [31:0] nt;
        if (m_pren[0]) begin
            nt = m_pend ? m_shadow : f_next(m_time);
            m_time = nt;
            m_pend = 1'b0;
            m_flags[0] = 1'b1;
            if (nt == m_alarm) m_flags[1] = 1'b1;
            if (m_sw != 16'd0) begin
                m_sw = m_sw - 16'd1;
                if (m_sw == 16'd0) m_flags[2] = 1'b1;
            end
        end
    endtask

    task automatic bus_op(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] d, output logic [31:0] rd, output logic [1:0] ec);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd = bus_rdata; ec = bus_err_code;
        if (wr && f_err(a, sz) == 2'd0) model_write(a, sz, d);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        logic [31:0] rd; logic [1:0] ec;
        bus_op(1'b1, a, sz, d, rd, ec);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [2:0] sz);
        logic [31:0] rd; logic [1:0] ec;
        bus_op(1'b0, a, sz, 32'd0, rd, ec);
        chk(tag, rd, f_read(a, sz));
        chk(tag, {30'd0, ec}, {30'd0, f_err(a, sz)});
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        model_tick();
    endtask

    task automatic irq_chk(input string tag);
        chk(tag, {31'd0, irq}, {31'd0, |(f_flags() & m_mask)});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] rd; logic [1:0] ec;
        void'($urandom(32'h00c0ffee));
        m_time = '0; m_shadow = '0; m_alarm = '0; m_mask = '0; m_pren = '0;
        m_sw = '0; m_flags = '0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'd0);
        chk("R1 err", {30'd0, bus_err_code}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 6; i++) rd_chk("R1 reg", 8'(i * 4), 3'd4);

        // R11 tick with counting disabled
        do_tick();
        rd_chk("R11 time held", 8'h00, 3'd4);
        rd_chk("R11 flags held", 8'h08, 3'd4);

        // R2 counting
        wr_reg(8'h14, 3'd2, 32'h1);
        do_tick();
        rd_chk("R2 one second", 8'h00, 3'd4);
        chk("R2 value", m_time, 32'h1);

        // R5 load and R3 full carry
        wr_reg(8'h00, 3'd4, f_pack(5, 23, 59, 59));
        rd_chk("R5 time unchanged", 8'h00, 3'd4);
        rd_chk("R5 pending flag", 8'h08, 3'd2);
        do_tick();
        rd_chk("R5 loaded", 8'h00, 3'd4);
        do_tick();
        rd_chk("R3 day carry", 8'h00, 3'd4);
        chk("R3 day carry value", m_time, f_pack(6, 0, 0, 0));
        rd_chk("R5 pending cleared", 8'h08, 3'd4);

        // R3 day wrap and out-of-range fields
        wr_reg(8'h00, 3'd4, f_pack(32767, 23, 59, 59));
        do_tick(); do_tick();
        rd_chk("R3 day wrap", 8'h00, 3'd4);
        chk("R3 wrap value", m_time, 32'd0);
        wr_reg(8'h00, 3'd4, f_pack(2, 30, 63, 63));
        do_tick(); do_tick();
        rd_chk("R3 out of range", 8'h00, 3'd4);

        // R5 half-word load keeps upper half
        wr_reg(8'h00, 3'd2, 32'hFFFF_0123);
        do_tick();
        rd_chk("R5 half load", 8'h00, 3'd4);

        // R6 write-one-to-clear, protected bit
        wr_reg(8'h00, 3'd4, f_pack(1, 1, 1, 1));
        wr_reg(8'h08, 3'd2, 32'h0000_FFFF);
        rd_chk("R6 clear keeps bit14", 8'h08, 3'd4);
        do_tick();
        wr_reg(8'h08, 3'd4, 32'h0000_0002);
        rd_chk("R6 partial clear", 8'h08, 3'd4);

        // R7 access errors
        bus_op(1'b0, 8'h40, 3'd1, 32'd0, rd, ec);
        chk("R7 size before map", {30'd0, ec}, 32'd1);
        chk("R7 error data", rd, 32'd0);
        bus_op(1'b0, 8'h40, 3'd4, 32'd0, rd, ec);
        chk("R7 unmapped", {30'd0, ec}, 32'd2);
        bus_op(1'b0, 8'h06, 3'd2, 32'd0, rd, ec);
        chk("R7 misaligned", {30'd0, ec}, 32'd2);
        bus_op(1'b1, 8'h04, 3'd3, 32'h0000_FFFF, rd, ec);
        chk("R7 bad size code", {30'd0, ec}, 32'd1);
        rd_chk("R7 no write effect", 8'h04, 3'd4);

        // R12 idle response
        @(negedge clk);
        chk("R12 idle data", bus_rdata, 32'd0);

        // R8 alarm and R10 irq
        wr_reg(8'h08, 3'd4, 32'h7);
        wr_reg(8'h10, 3'd4, f_next(m_time));
        wr_reg(8'h04, 3'd4, 32'h2);
        irq_chk("R10 masked quiet");
        do_tick();
        rd_chk("R8 alarm flag", 8'h08, 3'd4);
        irq_chk("R10 alarm irq");
        chk("R10 irq high", {31'd0, irq}, 32'd1);
        wr_reg(8'h08, 3'd4, 32'h2);
        irq_chk("R10 cleared");

        // R4 half access to 32-bit register
        wr_reg(8'h10, 3'd4, 32'h1234_5678);
        wr_reg(8'h10, 3'd2, 32'hFFFF_ABCD);
        rd_chk("R4 alarm full", 8'h10, 3'd4);
        rd_chk("R4 alarm half", 8'h10, 3'd2);
        wr_reg(8'h14, 3'd4, 32'hFFFF_0001);
        rd_chk("R4 zero extend", 8'h14, 3'd4);

        // R9 stopwatch
        wr_reg(8'h08, 3'd4, 32'h7);
        wr_reg(8'h0C, 3'd2, 32'h3);
        do_tick(); do_tick();
        rd_chk("R9 stopwatch mid", 8'h0C, 3'd2);
        rd_chk("R9 no flag yet", 8'h08, 3'd4);
        do_tick();
        rd_chk("R9 stopwatch zero", 8'h0C, 3'd2);
        rd_chk("R9 stopwatch flag", 8'h08, 3'd4);
        do_tick();
        rd_chk("R9 stays zero", 8'h0C, 3'd4);

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [7:0]  a;
            logic [2:0]  sz;
            logic [31:0] d;
            op = int'($urandom % 8);
            a  = 8'(($urandom % 6) * 4);
            sz = ($urandom % 2) ? 3'd4 : 3'd2;
            d  = $urandom;
            case (op)
                0, 1, 2: do_tick();
                3: begin
                    if (a == 8'h0C) d = $urandom % 6;
                    if (a == 8'h14) d = ($urandom % 4 != 0) ? 32'h1 : 32'h0;
                    if (a == 8'h10 && ($urandom % 2)) begin d = f_next(m_time); sz = 3'd4; end
                    if (a == 8'h00 && ($urandom % 2)) d = f_pack(int'($urandom % 32768), 23, 59, 58);
                    wr_reg(a, sz, d);
                end
                4, 5: rd_chk("R4 random read", a, sz);
                6: begin
                    logic [7:0] ba; logic [2:0] bs;
                    ba = 8'($urandom);
                    bs = 3'($urandom);
                    bus_op(1'b1, ba, bs, $urandom, rd, ec);
                    chk("R7 random code", {30'd0, ec}, {30'd0, f_err(ba, bs)});
                    chk("R7 random data", rd, 32'd0);
                end
                default: rd_chk("R2 random time", 8'h00, 3'd4);
            endcase
            irq_chk("R10 random irq");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule